// File: doc/BRIEF.md
# Registered-Read SEC/DED Memory EDAC

This block guards a 16-bit memory word with an extended Hamming code that corrects any one flipped bit and flags any two flipped bits. It has two paths. On the write side it turns the outgoing data word into six check bits, which are stored next to the word. On the read side it takes the raw word and the six stored check bits from memory. It then produces a corrected word and two error flags.

The read inputs are not decoded directly. A register samples both buses on every rising clock edge, and the syndrome, classification and correction logic work only on that stored copy. A memory bit that oscillates or sits at a marginal level is therefore reduced to whatever value it had at the sampling edge. The corrected bus and flags change only just after a clock edge, never between edges. The read path has one cycle of latency.

The decoder sorts each captured word into one of four classes. `EC_CLEAN` means no error was found. `EC_DATA_FIX` means one data bit was wrong and has been flipped back. `EC_CHECK_FIX` means one check bit was wrong and the data is already good. `EC_DOUBLE` means the error cannot be corrected. There are no other states and no transitions between them: every captured word is classified on its own, and the class is re-evaluated on each clock edge.

Top module: `edac_regread_secded`

## Requirements
- R1: The code layout is as follows.
  - Number the code positions 1 to 21.
  - Data bit i takes the i-th position, in ascending order, that is not a power of two. So data bit 0 is at position 3 and data bit 15 is at position 21.
  - Check bit k, for k from 0 to 4, is the XOR of every data bit whose position has bit k set.
  - Check bit 5 is the XOR of all 16 data bits and check bits 0 to 4.
  - `wr_check` always holds these six bits for the current `wr_data`.
- R2: When a valid codeword is read, `cor_data` equals the read data, and `err_single` and `err_double` are both 0.
- R3: When exactly one data bit of a valid codeword is inverted, `cor_data` equals the original word, `err_single` is 1 and `err_double` is 0.
- R4: When exactly one of check bits 0 to 4 is inverted, `cor_data` equals the read data, `err_single` is 1 and `err_double` is 0.
- R5: When only check bit 5 (the overall parity) is inverted, `cor_data` equals the read data, `err_single` is 1 and `err_double` is 0.
- R6: The word 0xAAAA read back as 0xAAAB, with the check bits of 0xAAAA, yields 0xAAAA with `err_single` set.
- R7: Any two inverted bits among the 22 stored bits give `err_double` = 1 and `err_single` = 0. In that case `cor_data` equals the raw read data, with no correction applied.
- R8: The outputs reflect the read inputs sampled at the previous rising clock edge. A change of the inputs between edges leaves the outputs unchanged until the next edge.
- R9: If a read input bit toggles several times between two edges, the outputs stay constant during the toggling. After the next edge they show the decode of the value present at that edge.
- R10: While `rst` is high at a rising edge, the capture register is cleared. After that edge, `cor_data` is 0 and both flags are 0.
- R11: `err_single` and `err_double` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the read capture register samples on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | 16 | Data word about to be written to memory |
| wr_check | output | 6 | Check bits for `wr_data`; combinational |
| rd_data | input | 16 | Raw data word read from memory |
| rd_check | input | 6 | Raw check bits read from memory |
| cor_data | output | 16 | Corrected data word, one cycle after capture |
| err_single | output | 1 | A single-bit error was found and handled |
| err_double | output | 1 | An uncorrectable error was found |

## Verification
The assertions assume two things. First, reset is applied before the first check. Second, the read buses are settled at each rising edge; they may change, or toggle, only between edges. That assumption lets an equality between consecutive samples stand for an unchanged capture. The bench drives every read value on the falling edge or at fractions of the period inside a cycle, and it never changes an input at a rising edge. In the same way, the self-consistency property between the write and read paths uses only valid codewords built from the R1 layout.

// File: rtl/edac_pkg.sv
package edac_pkg;

    // Number of Hamming check bits needed for a data word of width dw.
    function automatic int ham_bits(input int dw);
        for (int k = 1; k < 16; k++) begin
            if ((1 << k) >= dw + k + 1) return k;
        end
        return 16;
    endfunction

    // Code position of data bit idx: the idx-th position, counting upward
    // from 1, that is not a power of two.
    function automatic int data_pos(input int idx);
        int found;
        int seen;
        found = 0;
        seen  = 0;
        for (int q = 1; q < 256; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (seen == idx) found = q;
                seen = seen + 1;
            end
        end
        return found;
    endfunction

    // Mask of the data bits covered by Hamming check bit k.
    function automatic logic [63:0] cover_mask(input int k, input int dw);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < dw; i++) begin
            if (((data_pos(i) >> k) & 1) != 0) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Outcome of decoding one captured word.
    typedef enum logic [1:0] {
        EC_CLEAN     = 2'd0,
        EC_DATA_FIX  = 2'd1,
        EC_CHECK_FIX = 2'd2,
        EC_DOUBLE    = 2'd3
    } err_class_e;

endpackage

// File: rtl/edac_encode.sv
module edac_encode #(
    parameter int DATA_W = 16,
    parameter int HAM_W  = edac_pkg::ham_bits(DATA_W),
    localparam int CHK_W = HAM_W + 1
) (
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  check
);
    logic [HAM_W-1:0] ham;

    // One parity tree for each Hamming check bit.
    for (genvar k = 0; k < HAM_W; k++) begin : g_ham
        localparam logic [63:0] FULL_MASK = edac_pkg::cover_mask(k, DATA_W);
        localparam logic [DATA_W-1:0] MASK = FULL_MASK[DATA_W-1:0];
        assign ham[k] = ^(data & MASK);
    end

    // The overall parity bit makes the whole codeword even.
    assign check = {(^data) ^ (^ham), ham};

endmodule

// File: rtl/edac_capture.sv
module edac_capture #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CHK_W-1:0]  in_check,
    output logic [DATA_W-1:0] q_data,
    output logic [CHK_W-1:0]  q_check
);
    // The decode logic only ever sees these stored values.
    always_ff @(posedge clk) begin
        if (rst) begin
            q_data  <= '0;
            q_check <= '0;
        end else begin
            q_data  <= in_data;
            q_check <= in_check;
        end
    end

endmodule

// File: rtl/edac_syndrome.sv
module edac_syndrome #(
    parameter int DATA_W = 16,
    parameter int HAM_W  = edac_pkg::ham_bits(DATA_W),
    localparam int CHK_W = HAM_W + 1
) (
    input  logic [DATA_W-1:0] q_data,
    input  logic [CHK_W-1:0]  q_check,
    output logic [HAM_W-1:0]  syn,
    output logic              par_err
);
    logic [CHK_W-1:0] regen;

    edac_encode #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_regen (
        .data  (q_data),
        .check (regen)
    );

    // The syndrome names the code position in error.
    assign syn     = regen[HAM_W-1:0] ^ q_check[HAM_W-1:0];
    // Parity over all stored bits; odd means an odd number of flips.
    assign par_err = (^q_data) ^ (^q_check);

endmodule

// File: rtl/edac_fix.sv
module edac_fix #(
    parameter int DATA_W = 16,
    parameter int HAM_W  = edac_pkg::ham_bits(DATA_W)
) (
    input  logic [DATA_W-1:0]    q_data,
    input  logic [HAM_W-1:0]     syn,
    input  logic                 par_err,
    output logic [DATA_W-1:0]    fixed_data,
    output edac_pkg::err_class_e cls
);
    import edac_pkg::*;

    logic [DATA_W-1:0] flip;
    logic              hit_data;
    logic              syn_zero;
    logic              syn_single;

    // Match the syndrome against the position of each data bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        localparam logic [HAM_W-1:0] POS = HAM_W'(data_pos(i));
        assign flip[i] = (syn == POS);
    end

    assign hit_data   = |flip;
    assign syn_zero   = (syn == '0);
    assign syn_single = ((syn & (syn - HAM_W'(1))) == '0);

    always_comb begin
        unique case ({syn_zero, par_err})
            2'b10: cls = EC_CLEAN;
            2'b11: cls = EC_CHECK_FIX;   // only the overall parity bit flipped
            2'b00: cls = EC_DOUBLE;      // even count of flips, nonzero syndrome
            2'b01: begin
                if (hit_data)        cls = EC_DATA_FIX;
                else if (syn_single) cls = EC_CHECK_FIX;
                else                 cls = EC_DOUBLE; // position outside the word
            end
            default: cls = EC_DOUBLE;
        endcase
    end

    always_comb begin
        unique case (cls)
            EC_DATA_FIX: fixed_data = q_data ^ flip;
            default:     fixed_data = q_data;
        endcase
    end

endmodule

// File: rtl/edac_regread_secded.sv
module edac_regread_secded #(
    parameter int DATA_W = 16
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [DATA_W-1:0]                       wr_data,
    output logic [edac_pkg::ham_bits(DATA_W):0]     wr_check,
    input  logic [DATA_W-1:0]                       rd_data,
    input  logic [edac_pkg::ham_bits(DATA_W):0]     rd_check,
    output logic [DATA_W-1:0]                       cor_data,
    output logic                                    err_single,
    output logic                                    err_double
);
    import edac_pkg::*;

    localparam int HAM_W = ham_bits(DATA_W);
    localparam int CHK_W = HAM_W + 1;

    logic [DATA_W-1:0] q_data;
    logic [CHK_W-1:0]  q_check;
    logic [HAM_W-1:0]  syn;
    logic              par_err;
    logic [DATA_W-1:0] fixed_data;
    err_class_e        cls;

    // Write path: check-bit generation.
    edac_encode #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_wr_enc (
        .data  (wr_data),
        .check (wr_check)
    );

    // Read path: capture register, then the decode logic.
    edac_capture #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .in_data  (rd_data),
        .in_check (rd_check),
        .q_data   (q_data),
        .q_check  (q_check)
    );

    edac_syndrome #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_syn (
        .q_data  (q_data),
        .q_check (q_check),
        .syn     (syn),
        .par_err (par_err)
    );

    edac_fix #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_fix (
        .q_data     (q_data),
        .syn        (syn),
        .par_err    (par_err),
        .fixed_data (fixed_data),
        .cls        (cls)
    );

    // Map the error class to the output pins.
    always_comb begin
        cor_data = fixed_data;
        unique case (cls)
            EC_CLEAN:     begin err_single = 1'b0; err_double = 1'b0; end
            EC_DATA_FIX:  begin err_single = 1'b1; err_double = 1'b0; end
            EC_CHECK_FIX: begin err_single = 1'b1; err_double = 1'b0; end
            EC_DOUBLE:    begin err_single = 1'b0; err_double = 1'b1; end
            default:      begin err_single = 1'b0; err_double = 1'b1; end
        endcase
    end

endmodule

// File: rtl/edac_regread_secded_chk.sv
module edac_regread_secded_chk #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] wr_data,
    input logic [CHK_W-1:0]  wr_check,
    input logic [DATA_W-1:0] rd_data,
    input logic [CHK_W-1:0]  rd_check,
    input logic [DATA_W-1:0] cor_data,
    input logic              err_single,
    input logic              err_double
);
    // R11
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_single, err_double}));

    // R10
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cor_data == '0 && !err_single && !err_double));

    // R2
    clean_roundtrip_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_data) == $past(wr_data) && $past(rd_check) == $past(wr_check))
        |-> (cor_data == $past(rd_data) && !err_single && !err_double));

    // R7
    double_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        err_double |-> cor_data == $past(rd_data));

    // R3
    single_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        err_single |-> $countones(cor_data ^ $past(rd_data)) <= 1);

    // R8
    held_input_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(rd_data) && $stable(rd_check))
        |=> ($stable(cor_data) && $stable(err_single) && $stable(err_double)));

endmodule

bind edac_regread_secded edac_regread_secded_chk #(
    .DATA_W(DATA_W),
    .CHK_W (CHK_W)
) u_chk (.*);

// File: tb/edac_regread_secded_test.sv
`timescale 1ns/100ps
module edac_regread_secded_test;

    logic        clk;
    logic        rst;
    logic [15:0] wr_data;
    logic [5:0]  wr_check;
    logic [15:0] rd_data;
    logic [5:0]  rd_check;
    logic [15:0] cor_data;
    logic        err_single;
    logic        err_double;

    int nchk;
    int nfail;
    bit done;

    edac_regread_secded #(.DATA_W(16)) uut (
        .clk        (clk),
        .rst        (rst),
        .wr_data    (wr_data),
        .wr_check   (wr_check),
        .rd_data    (rd_data),
        .rd_check   (rd_check),
        .cor_data   (cor_data),
        .err_single (err_single),
        .err_double (err_double)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Code positions and check bits as laid out in R1.
    function automatic int pos_of(input int idx);
        int seen;
        seen = 0;
        for (int q = 3; q < 32; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (seen == idx) return q;
                seen++;
            end
        end
        return 0;
    endfunction

    function automatic logic [5:0] ref_check(input logic [15:0] d);
        logic [5:0] c;
        c = '0;
        for (int k = 0; k < 5; k++)
            for (int i = 0; i < 16; i++)
                if (((pos_of(i) >> k) & 1) != 0) c[k] = c[k] ^ d[i];
        c[5] = (^d) ^ (^c[4:0]);
        return c;
    endfunction

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one read word on the falling edge; sample after the next rising edge.
    task automatic read_word(input logic [15:0] d, input logic [5:0] c);
        @(negedge clk);
        rd_data  = d;
        rd_check = c;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        rd_data = 16'hFFFF;
        rd_check = 6'h3F;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R10 reset", {cor_data, err_single, err_double}, 18'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_encode();
        logic [15:0] pats [6] = '{16'h0000, 16'hFFFF, 16'hAAAA, 16'h5555, 16'h1234, 16'h8001};
        foreach (pats[j]) begin
            wr_data = pats[j];
            #0.5;
            chk("R1 wr_check", {12'h0, wr_check}, {12'h0, ref_check(pats[j])});
        end
    endtask

    task automatic t_clean();
        logic [15:0] pats [5] = '{16'h0000, 16'hFFFF, 16'hAAAA, 16'hC3A5, 16'h0F0F};
        foreach (pats[j]) begin
            read_word(pats[j], ref_check(pats[j]));
            chk("R2 clean", {cor_data, err_single, err_double}, {pats[j], 2'b00});
        end
    endtask

    task automatic t_single(input logic [15:0] d);
        for (int b = 0; b < 22; b++) begin
            logic [21:0] cw;
            cw = {ref_check(d), d};
            cw[b] = ~cw[b];
            read_word(cw[15:0], cw[21:16]);
            if (b < 16)
                chk("R3 data bit", {cor_data, err_single, err_double}, {d, 2'b10});
            else if (b < 21)
                chk("R4 check bit", {cor_data, err_single, err_double}, {d, 2'b10});
            else
                chk("R5 parity bit", {cor_data, err_single, err_double}, {d, 2'b10});
        end
    endtask

    task automatic t_example();
        read_word(16'hAAAB, ref_check(16'hAAAA));
        chk("R6 AAAB", {cor_data, err_single, err_double}, {16'hAAAA, 2'b10});
    endtask

    task automatic t_double(input logic [15:0] d);
        for (int a = 0; a < 22; a++) begin
            for (int b = a + 1; b < 22; b++) begin
                logic [21:0] cw;
                cw = {ref_check(d), d};
                cw[a] = ~cw[a];
                cw[b] = ~cw[b];
                read_word(cw[15:0], cw[21:16]);
                chk("R7 double", {cor_data, err_single, err_double}, {cw[15:0], 2'b01});
            end
        end
    endtask

    task automatic t_latency();
        read_word(16'h1111, ref_check(16'h1111));
        @(negedge clk);
        rd_data  = 16'h2222;
        rd_check = ref_check(16'h2222);
        #0.5;
        chk("R8 before edge", {cor_data, err_single, err_double}, {16'h1111, 2'b00});
        @(posedge clk);
        #1;
        chk("R8 after edge", {cor_data, err_single, err_double}, {16'h2222, 2'b00});
    endtask

    task automatic t_toggle(input int flips);
        logic [17:0] held;
        read_word(16'h1234, ref_check(16'h1234));
        held = {cor_data, err_single, err_double};
        for (int t = 0; t < flips; t++) begin
            #0.4;
            rd_data[0] = ~rd_data[0];
            #0.1;
            chk("R9 between edges", {cor_data, err_single, err_double}, held);
        end
        @(posedge clk);
        #1;
        if (flips % 2 == 1)
            chk("R9 odd toggles", {cor_data, err_single, err_double}, {16'h1234, 2'b10});
        else
            chk("R9 even toggles", {cor_data, err_single, err_double}, {16'h1234, 2'b00});
    endtask

    task automatic t_reset_mid();
        read_word(16'h00FF, ref_check(16'h0000));
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 reset mid-run", {cor_data, err_single, err_double}, 18'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        nchk = 0;
        nfail = 0;
        done = 1'b0;
        rst = 1'b1;
        wr_data = '0;
        rd_data = '0;
        rd_check = '0;
        t_reset();
        t_encode();
        t_clean();
        t_single(16'hAAAA);
        t_single(16'h6C31);
        t_example();
        t_double(16'hAAAA);
        t_double(16'h0000);
        t_latency();
        t_toggle(5);
        t_toggle(4);
        t_reset_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule